// File: doc/BRIEF.md
# Signature Flow Checker

The block watches the control flow of a program that has been split into blocks. On entering a block, the program writes the block's signature to the checker. The checker holds one legal sequence of signatures and keeps a position in it. Each incoming signature must equal the entry at that position, and it must arrive within that entry's own time budget, counted in clock cycles. A wrong signature, or a signature that never arrives, latches a fault. The fault carries a cause code and records both the expected and the received values. A program stuck in an endless loop, or one that jumps to the wrong block, is caught this way.

Software first fills the sequence table, with a signature and a cycle limit for each entry, and writes the index of the last entry. It then sets the enable bit. After the last entry the position returns to entry 0, so a periodic task can run through the same sequence again and again. The table is locked for the whole time checking is enabled.

The controller has three states. OFF means checking is disabled. WATCH means checking is active. FAULT means an error has been latched. The transitions are:
- *arm*: OFF to WATCH, on an enable write.
- *accept*: WATCH to WATCH, on a correct signature.
- *mismatch*: WATCH to FAULT, on a wrong signature.
- *expire*: WATCH to FAULT, when the budget runs out.
- *disarm*: WATCH or FAULT to OFF, on a write that clears the enable bit.

Top module: `sig_flow_checker`

## Requirements
- R1: After reset, `err_flag` is 0, `err_cause` is 00, `sts_active` is 0 and `sts_pos` is 0.
- R2: While disabled, signatures have no effect and no timeout is raised. A control write with `ctl_enable`=1 arms the checker at entry 0, and `ctl_last` is taken only while disabled.
- R3: When a signature equals the table entry at `sts_pos`, the position advances by one. When the position equals the last index, it returns to 0 instead.
- R4: When a signature differs from the entry at `sts_pos`, the checker enters FAULT. `err_cause` becomes 01, `err_expected` holds the table value and `err_received` holds the wrong value.
- R5: Let L be the limit of the current entry. A signature is judged if it arrives in any of the L+1 cycles that follow arming or the last acceptance. If none arrives in those cycles, the next clock edge enters FAULT with `err_cause` 10, `err_expected` holding the missing entry and `err_received` 0.
- R6: The interval timer restarts on every accepted signature, and each entry is timed against its own limit.
- R7: A fault is sticky. Further signatures and enable writes leave `err_flag`, `err_cause` and the captured values unchanged. Only a write with `ctl_enable`=0 clears them and returns the checker to OFF.
- R8: Table writes are ignored while the checker is in WATCH or FAULT.
- R9: `sts_active` is 1 in WATCH and FAULT and 0 in OFF. `sts_pos` shows the current position.
- R10: If a signature arrives in the same cycle the budget runs out, it is judged as a signature and not as a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_valid | input | 1 | Signature write strobe |
| sig_data | input | SIG_W | Signature value |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | PTR_W | Table entry index |
| tbl_sig | input | SIG_W | Expected signature for the entry |
| tbl_limit | input | TMR_W | Cycle budget for the entry |
| ctl_we | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable bit carried by a control write |
| ctl_last | input | PTR_W | Index of the last sequence entry |
| err_flag | output | 1 | Sticky fault indication |
| err_cause | output | 2 | 00 none, 01 wrong signature, 10 timeout |
| err_expected | output | SIG_W | Signature that was expected at the fault |
| err_received | output | SIG_W | Signature received at the fault (0 on timeout) |
| sts_active | output | 1 | Checking enabled |
| sts_pos | output | PTR_W | Current position in the sequence |

## Verification
A corrupted position shows up on `sts_pos` one cycle after the accepting edge. At the following signature it also raises a false cause-01 fault. A timer that fails to restart, or that uses the wrong entry's limit, shows up as a cause-10 fault at a cycle other than the L+1 boundary. The bench therefore probes the budget one cycle before expiry and exactly at expiry. A lost lock on the table, or a fault that is not sticky, becomes visible at the next signature after re-arming, or in the cycle after the disturbing write.

// File: rtl/flowchk_pkg.sv
package flowchk_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_FAULT = 2'd2
    } fc_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_MISMATCH = 2'b01,
        CAUSE_TIMEOUT  = 2'b10
    } fc_cause_e;

endpackage

// File: rtl/flowchk_table.sv
module flowchk_table #(
    parameter int DEPTH = 32,
    parameter int SIG_W = 16,
    parameter int TMR_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [SIG_W-1:0] wr_sig,
    input  logic [TMR_W-1:0] wr_lim,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [SIG_W-1:0] rd_sig,
    output logic [TMR_W-1:0] rd_lim
);

    logic [DEPTH-1:0][SIG_W-1:0] sig_q;
    logic [DEPTH-1:0][TMR_W-1:0] lim_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sig_q[g] <= '0;
                lim_q[g] <= '0;
            end else if (wr_en && !lock && (wr_addr == PTR_W'(g))) begin
                sig_q[g] <= wr_sig;
                lim_q[g] <= wr_lim;
            end
        end
    end

    assign rd_sig = sig_q[rd_addr];
    assign rd_lim = lim_q[rd_addr];

    // R8: a locked table keeps every entry
    assert_table_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(sig_q) && $stable(lim_q)));

endmodule

// File: rtl/flowchk_timer.sv
module flowchk_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);

    logic [TMR_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    assign expired = (count_q == limit);

    // R6: a restart request zeroes the interval count
    assert_timer_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0));

    // R5: while timing, the count never passes the budget
    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (count_q <= limit));

endmodule

// File: rtl/sig_flow_checker.sv
module sig_flow_checker
    import flowchk_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int SIG_W = 16,
    parameter int TMR_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_valid,
    input  logic [SIG_W-1:0] sig_data,
    input  logic             tbl_we,
    input  logic [PTR_W-1:0] tbl_addr,
    input  logic [SIG_W-1:0] tbl_sig,
    input  logic [TMR_W-1:0] tbl_limit,
    input  logic             ctl_we,
    input  logic             ctl_enable,
    input  logic [PTR_W-1:0] ctl_last,
    output logic             err_flag,
    output logic [1:0]       err_cause,
    output logic [SIG_W-1:0] err_expected,
    output logic [SIG_W-1:0] err_received,
    output logic             sts_active,
    output logic [PTR_W-1:0] sts_pos
);

    fc_state_e        state_q, state_d;
    fc_cause_e        cause_q;
    logic [PTR_W-1:0] ptr_q, last_q;
    logic [SIG_W-1:0] exp_q, rcv_q;
    logic [SIG_W-1:0] cur_sig;
    logic [TMR_W-1:0] cur_lim;
    logic             tmr_expired, tmr_clr;
    logic             go_on, go_off, hit, miss, accept;

    assign go_on  = ctl_we && ctl_enable;
    assign go_off = ctl_we && !ctl_enable;
    assign hit    = sig_valid && (sig_data == cur_sig);
    assign miss   = sig_valid && (sig_data != cur_sig);
    assign accept = (state_q == ST_WATCH) && !go_off && hit;

    flowchk_table #(.DEPTH(DEPTH), .SIG_W(SIG_W), .TMR_W(TMR_W)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (state_q != ST_OFF),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_sig  (tbl_sig),
        .wr_lim  (tbl_limit),
        .rd_addr (ptr_q),
        .rd_sig  (cur_sig),
        .rd_lim  (cur_lim)
    );

    assign tmr_clr = (state_q != ST_WATCH) || accept;

    flowchk_timer #(.TMR_W(TMR_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .limit   (cur_lim),
        .expired (tmr_expired)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (go_on) state_d = ST_WATCH;                 // arm
            end
            ST_WATCH: begin
                if (go_off)                     state_d = ST_OFF;   // disarm
                else if (miss)                  state_d = ST_FAULT; // mismatch
                else if (!sig_valid && tmr_expired) state_d = ST_FAULT; // expire
            end
            ST_FAULT: begin
                if (go_off) state_d = ST_OFF;                  // disarm
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // position, configuration and fault capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            last_q  <= '0;
            cause_q <= CAUSE_NONE;
            exp_q   <= '0;
            rcv_q   <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (ctl_we) last_q <= ctl_last;
                    if (go_on)  ptr_q  <= '0;
                end
                ST_WATCH: begin
                    if (go_off) begin
                        ptr_q   <= '0;
                        cause_q <= CAUSE_NONE;
                        exp_q   <= '0;
                        rcv_q   <= '0;
                    end else if (accept) begin
                        ptr_q <= (ptr_q == last_q) ? '0 : ptr_q + 1'b1;
                    end else if (state_d == ST_FAULT) begin
                        cause_q <= miss ? CAUSE_MISMATCH : CAUSE_TIMEOUT;
                        exp_q   <= cur_sig;
                        rcv_q   <= miss ? sig_data : '0;
                    end
                end
                ST_FAULT: begin
                    if (go_off) begin
                        ptr_q   <= '0;
                        cause_q <= CAUSE_NONE;
                        exp_q   <= '0;
                        rcv_q   <= '0;
                    end
                end
                default: ptr_q <= '0;
            endcase
        end
    end

    assign err_flag     = (state_q == ST_FAULT);
    assign err_cause    = cause_q;
    assign err_expected = exp_q;
    assign err_received = rcv_q;
    assign sts_active   = (state_q != ST_OFF);
    assign sts_pos      = ptr_q;

    // R3: the position stays inside the programmed sequence
    assert_pos_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sts_active |-> (ptr_q <= last_q));

    // R3: acceptance at the last entry returns to entry 0
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (ptr_q == last_q)) |=> (ptr_q == '0));

    // R4: a wrong signature latches the mismatch cause
    assert_mismatch_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WATCH) && !go_off && miss) |=> (err_flag && (err_cause == CAUSE_MISMATCH)));

    // R5: an expired budget without a signature latches the timeout cause
    assert_timeout_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WATCH) && !go_off && !sig_valid && tmr_expired)
            |=> (err_flag && (err_cause == CAUSE_TIMEOUT) && (err_received == '0)));

    // R7: a latched fault and its record hold until disarm
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !go_off) |=> (err_flag && $stable(err_cause)
                                   && $stable(err_expected) && $stable(err_received)));

    // R2: no fault can appear while disabled
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_active && !go_on) |=> !err_flag);

endmodule

// File: tb/test_sig_flow_checker.sv
`timescale 1ns/1ps
module test_sig_flow_checker;

    localparam int PTR_W = 5;
    localparam int NV    = 10;
    localparam longint WD_NS = 64'd200000 * 64'd20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_valid = 1'b0;
    logic [15:0] sig_data = '0;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_addr = '0;
    logic [15:0] tbl_sig = '0;
    logic [15:0] tbl_limit = '0;
    logic        ctl_we = 1'b0;
    logic        ctl_enable = 1'b0;
    logic [4:0]  ctl_last = '0;
    logic        err_flag;
    logic [1:0]  err_cause;
    logic [15:0] err_expected;
    logic [15:0] err_received;
    logic        sts_active;
    logic [4:0]  sts_pos;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sig_flow_checker i_sig_flow_checker (
        .clk(clk), .rst_n(rst_n),
        .sig_valid(sig_valid), .sig_data(sig_data),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_sig(tbl_sig), .tbl_limit(tbl_limit),
        .ctl_we(ctl_we), .ctl_enable(ctl_enable), .ctl_last(ctl_last),
        .err_flag(err_flag), .err_cause(err_cause),
        .err_expected(err_expected), .err_received(err_received),
        .sts_active(sts_active), .sts_pos(sts_pos)
    );

    // {valid, data, exp_flag, exp_cause, exp_pos}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 16'hA0B0, 1'b0, 2'b00, 5'd1},
        {1'b1, 16'hA1B1, 1'b0, 2'b00, 5'd2},
        {1'b0, 16'h0000, 1'b0, 2'b00, 5'd2},
        {1'b0, 16'h0000, 1'b0, 2'b00, 5'd2},
        {1'b0, 16'h0000, 1'b0, 2'b00, 5'd2},
        {1'b0, 16'h0000, 1'b0, 2'b00, 5'd2},
        {1'b1, 16'hA2B2, 1'b0, 2'b00, 5'd3},
        {1'b1, 16'hA3B3, 1'b0, 2'b00, 5'd0},
        {1'b1, 16'hA0B0, 1'b0, 2'b00, 5'd1},
        {1'b1, 16'h1234, 1'b1, 2'b01, 5'd1}
    };

    function automatic logic [15:0] sig_of(input int i);
        return 16'hA0B0 + 16'h0101 * 16'(i);
    endfunction

    function automatic logic [15:0] lim_of(input int i);
        return (i == 2) ? 16'd6 : 16'd3;
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_entry(input int a, input logic [15:0] s, input logic [15:0] l);
        tbl_we = 1'b1; tbl_addr = 5'(a); tbl_sig = s; tbl_limit = l;
        cyc();
        tbl_we = 1'b0;
    endtask

    task automatic ctl(input logic en, input logic [4:0] last);
        ctl_we = 1'b1; ctl_enable = en; ctl_last = last;
        cyc();
        ctl_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] s);
        sig_valid = 1'b1; sig_data = s;
        cyc();
        sig_valid = 1'b0;
    endtask

    initial begin
        #(WD_NS);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flag", 32'(err_flag), 0);
        chk("R1 cause", 32'(err_cause), 0);
        chk("R1 active", 32'(sts_active), 0);
        chk("R1 pos", 32'(sts_pos), 0);

        // table: entries 0..3 form the sequence, entry 4 lies outside it
        for (int i = 0; i < 4; i++) wr_entry(i, sig_of(i), lim_of(i));
        wr_entry(4, 16'hBEEF, 16'd3);
        ctl(1'b0, 5'd3);

        // R2: signatures are ignored while disabled
        send(16'h5555);
        idle(30);
        chk("R2 flag while off", 32'(err_flag), 0);
        chk("R9 active while off", 32'(sts_active), 0);

        ctl(1'b1, 5'd3);
        chk("R2 armed at entry 0", 32'(sts_pos), 0);
        chk("R9 active when armed", 32'(sts_active), 1);

        // vector walk: R3 advance/wrap, R6 per-entry budget, R4 mismatch
        for (int i = 0; i < NV; i++) begin
            sig_valid = VEC[i][24];
            sig_data  = VEC[i][23:8];
            cyc();
            sig_valid = 1'b0;
            chk("R3 R6 vector pos", 32'(sts_pos), 32'(VEC[i][4:0]));
            chk("R4 R6 vector flag", 32'(err_flag), 32'(VEC[i][7]));
            chk("R4 vector cause", 32'(err_cause), 32'(VEC[i][6:5]));
        end
        chk("R4 expected", 32'(err_expected), 32'h0000A1B1);
        chk("R4 received", 32'(err_received), 32'h00001234);

        // R7: sticky fault ignores signatures and enable writes
        sig_valid = 1'b1; sig_data = 16'hA1B1;
        ctl_we = 1'b1; ctl_enable = 1'b1; ctl_last = 5'd3;
        cyc();
        sig_valid = 1'b0; ctl_we = 1'b0;
        chk("R7 flag held", 32'(err_flag), 1);
        chk("R7 cause held", 32'(err_cause), 1);
        chk("R7 expected held", 32'(err_expected), 32'h0000A1B1);
        chk("R7 received held", 32'(err_received), 32'h00001234);

        // R8: write while in fault must be ignored
        wr_entry(0, 16'hFFFF, 16'd3);
        ctl(1'b0, 5'd3);
        chk("R7 cleared flag", 32'(err_flag), 0);
        chk("R7 cleared cause", 32'(err_cause), 0);
        chk("R9 inactive", 32'(sts_active), 0);

        ctl(1'b1, 5'd3);
        // R8: write while watching must be ignored
        wr_entry(1, 16'hFFFF, 16'd3);
        send(sig_of(0));
        chk("R8 entry 0 unchanged", 32'(sts_pos), 1);
        send(sig_of(1));
        chk("R8 entry 1 unchanged", 32'(sts_pos), 2);
        chk("R8 no fault", 32'(err_flag), 0);

        // R5/R10: signature in the last budget cycle of entry 2 (limit 6)
        idle(6);
        chk("R5 no timeout before limit", 32'(err_flag), 0);
        send(sig_of(2));
        chk("R10 accepted at expiry", 32'(sts_pos), 3);
        chk("R10 no fault", 32'(err_flag), 0);

        // R5: entry 3 (limit 3) times out after four silent cycles
        idle(3);
        chk("R5 still waiting", 32'(err_flag), 0);
        idle(1);
        chk("R5 timeout flag", 32'(err_flag), 1);
        chk("R5 timeout cause", 32'(err_cause), 2);
        chk("R5 timeout expected", 32'(err_expected), 32'h0000A3B3);
        chk("R5 timeout received", 32'(err_received), 0);

        // R2: disabled again, no timeout and no effect of signatures
        ctl(1'b0, 5'd3);
        for (int k = 0; k < 20; k++) send(16'(k * 16'h0F0F));
        chk("R2 quiet when off", 32'(err_flag), 0);
        chk("R2 pos when off", 32'(sts_pos), 0);
        chk("R9 off", 32'(sts_active), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule